// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block produces and distributes the serial clock of an SPI port. As a master it divides the peripheral clock by a power of two chosen with a 4-bit code. It drives the serial clock pin with a selectable idle level and edge phase, and it frames each transfer as a fixed number of bits. As a slave it takes the clock from the pin, synchronizes it into the peripheral clock domain and turns its edges into the same strobes. Either way, a neighbouring shift register receives a one-cycle sample strobe and a one-cycle shift strobe for every bit, plus a pulse when the last bit of a frame has been clocked.

In normal master operation a frame begins on a start pulse from the data path. In master receive-only operation no write data is needed: the clock starts as soon as the block is enabled and runs frame after frame. When enable is removed, the frame in progress is allowed to finish before the clock stops.

Top module: `spi_sck_gen`

## Requirements
- R1: In master mode, whenever no frame is active, `sck_out` rests at the level of `cpol` (0 or 1).
- R2: In master mode each half period of `sck_out` lasts 2^n peripheral clocks for divider code n from 0 to 9. Codes 10 to 15 behave as code 9, giving a full period of 1024 clocks.
- R3: The leading edge of a bit is the transition away from the idle level. With `cpha`=0 the sample strobe marks leading edges and the shift strobe marks trailing edges; with `cpha`=1 the roles swap. In master mode each strobe is high for one cycle, in the same cycle that `sck_out` takes its new value, and the two strobes are never high together.
- R4: A frame is FRAME_BITS bits (default 8), so it has 2*FRAME_BITS clock edges. `frame_done` pulses for one cycle together with the strobe of the last edge.
- R5: `sck_oe` is high only in master mode while the block is enabled or a frame is still running. It is always low in slave mode.
- R6: In master mode with `rx_only`=1, the clock starts once `en` is high, without any `frame_start`, and frames follow each other with no gap in the edge spacing.
- R7: In master receive-only mode, dropping `en` in the middle of a frame lets that frame run to its last edge. After that no further edge or strobe appears.
- R8: In slave mode `sck_in` passes through a two-flop synchronizer. Each of its edges yields exactly one strobe, chosen by `cpol` and `cpha` as in R3. The peripheral clock must run at least 4 times faster than `sck_in`.
- R9: In master mode `frame_start` is ignored while `en` is low and while a frame is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| master | input | 1 | 1 = drive the clock, 0 = take it from `sck_in` |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| div_code | input | 4 | Divider code n, half period 2^n clocks (saturates at 9) |
| rx_only | input | 1 | Master receive-only, free-running clock |
| frame_start | input | 1 | Pulse that begins a master frame |
| sck_in | input | 1 | Serial clock from the pin in slave mode |
| sck_out | output | 1 | Serial clock value for the pin in master mode |
| sck_oe | output | 1 | Output enable of the clock pin |
| sample_stb | output | 1 | One-cycle strobe: sample the input line |
| shift_stb | output | 1 | One-cycle strobe: shift out the next bit |
| frame_done | output | 1 | One-cycle pulse on the last edge of a frame |

## Verification
The bench builds the block with its defaults: 8-bit frames and a divider limit of 2^9. That lets a full frame at the saturated code 12 (8192 cycles) run next to frames at codes 0, 2 and 3, so both the 2^n rule and its ceiling are measured edge by edge. The 16-edge frame is short enough to run three back-to-back receive-only frames with a mid-frame disable, and a slave frame at an 8-cycle half period, within a few thousand cycles each.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } sck_mode_e;

    typedef struct packed {
        logic valid;
        logic level;
    } sck_edge_t;

    function automatic int unsigned sat_shift(input logic [3:0] code,
                                              input int unsigned max_log);
        int unsigned c;
        c = 32'(code);
        return (c > max_log) ? max_log : c;
    endfunction

endpackage

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spi_sck_pkg::*;
#(
    parameter int MAX_LOG = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [3:0] code,
    output logic       tick
);
    localparam int CNT_W = MAX_LOG + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'((64'd1 << sat_shift(code, MAX_LOG)) - 64'd1);
        tick    = !clr && (cnt_q >= half_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && half_m1 != '0) |=> !tick);

endmodule

// File: rtl/spi_sck_sync.sv
module spi_sck_sync
    import spi_sck_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_in,
    output sck_edge_t edge_o
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], sck_in};
    end

    always_comb begin
        edge_o.valid = sync_q[1] ^ sync_q[2];
        edge_o.level = sync_q[1];
    end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_sck_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int MAX_LOG    = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       master,
    input  logic       cpol,
    input  logic       cpha,
    input  logic [3:0] div_code,
    input  logic       rx_only,
    input  logic       frame_start,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    output logic       sample_stb,
    output logic       shift_stb,
    output logic       frame_done
);
    localparam int EDGES = 2 * FRAME_BITS;
    localparam int IDX_W = $clog2(EDGES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(EDGES - 1);

    logic             active_q;
    logic             sck_q;
    logic             tick;
    logic [IDX_W-1:0] idx_q;
    sck_edge_t        sedge;
    sck_mode_e        mode;
    logic             edge_ev;
    logic             leading;
    logic             is_sample;
    logic             last_edge;
    logic             idx_clr;

    spi_sck_prescaler #(.MAX_LOG(MAX_LOG)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (!active_q),
        .code (div_code),
        .tick (tick)
    );

    spi_sck_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .sck_in (sck_in),
        .edge_o (sedge)
    );

    always_comb begin
        mode    = master ? MODE_MASTER : MODE_SLAVE;
        edge_ev = 1'b0;
        leading = 1'b0;
        idx_clr = 1'b0;
        unique case (mode)
            MODE_MASTER: begin
                edge_ev = active_q && tick;
                leading = ~idx_q[0];
                idx_clr = !active_q;
            end
            MODE_SLAVE: begin
                edge_ev = en && sedge.valid;
                leading = sedge.level != cpol;
                idx_clr = !en;
            end
            default: ;
        endcase
        is_sample = leading ^ cpha;
        last_edge = (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            sck_q      <= 1'b0;
            idx_q      <= '0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            sample_stb <= edge_ev && is_sample;
            shift_stb  <= edge_ev && !is_sample;
            frame_done <= edge_ev && last_edge;

            if (edge_ev)      idx_q <= last_edge ? '0 : idx_q + 1'b1;
            else if (idx_clr) idx_q <= '0;

            if (mode != MODE_MASTER)  active_q <= 1'b0;
            else if (!active_q)       active_q <= en && (rx_only || frame_start);
            else if (tick && last_edge) active_q <= rx_only && en;

            if (!active_q)  sck_q <= cpol;
            else if (tick)  sck_q <= ~sck_q;
        end
    end

    assign sck_out = sck_q;
    assign sck_oe  = master && (en || active_q);

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && !$past(rst) && !active_q && !$past(active_q)
         && $stable(cpol)) |-> (sck_out == cpol));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && shift_stb));

    // R3
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && (sample_stb || shift_stb))
        |-> (sck_out != $past(sck_out)));

    // R4
    done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (sample_stb || shift_stb));

endmodule

// File: tb/sim_spi_sck_gen.sv
module sim_spi_sck_gen;

    typedef struct {
        bit smp;
        bit chk_lvl;
        bit lvl;
        int gap;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, master = 1'b1, cpol = 1'b1, cpha = 1'b0;
    logic [3:0] div_code = 4'd0;
    logic       rx_only = 1'b0, frame_start = 1'b0, sck_in = 1'b0;
    logic       sck_out, sck_oe, sample_stb, shift_stb, frame_done;

    int checks = 0, failures = 0, cyc = 0, last_cyc = 0, done_cnt = 0;
    bit finished = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sck_gen u0 (
        .clk(clk), .rst(rst), .en(en), .master(master), .cpol(cpol), .cpha(cpha),
        .div_code(div_code), .rx_only(rx_only), .frame_start(frame_start),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic push_frame(input bit pol, input bit pha, input int half,
                              input bit chain, input bit lvl_chk);
        for (int e = 0; e < 16; e++) begin
            exp_t it;
            bit lead;
            lead       = (e % 2) == 0;
            it.smp     = lead ^ pha;
            it.chk_lvl = lvl_chk;
            it.lvl     = lead ? ~pol : pol;
            it.gap     = (e == 0 && !chain) ? 0 : half;
            q.push_back(it);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_done) done_cnt++;
            if (sample_stb || shift_stb) begin
                chk(!(sample_stb && shift_stb), "R3 both strobes high", 1, 0);
                if (q.size() == 0) begin
                    chk(0, "R7/R9 unexpected strobe", 1, 0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk(sample_stb == it.smp, "R3 strobe kind (1=sample)",
                        int'(sample_stb), int'(it.smp));
                    if (it.chk_lvl)
                        chk(sck_out == it.lvl, "R3 sck level at strobe",
                            int'(sck_out), int'(it.lvl));
                    if (it.gap != 0)
                        chk(cyc - last_cyc == it.gap, "R2/R8 edge spacing",
                            cyc - last_cyc, it.gap);
                end
                last_cyc = cyc;
            end
        end
    end

    task automatic wait_done(input int target);
        int t = 0;
        while (done_cnt < target && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic master_frame(input logic [3:0] code, input bit pol,
                                input bit pha, input int half, input string tag);
        int base;
        @(negedge clk);
        div_code = code; cpol = pol; cpha = pha;
        repeat (3) @(negedge clk);
        chk(sck_out == pol, {tag, " R1 idle level before frame"}, int'(sck_out), int'(pol));
        base = done_cnt;
        push_frame(pol, pha, half, 0, 1);
        pulse_start();
        wait_done(base + 1);
        repeat (4) @(negedge clk);
        chk(done_cnt == base + 1, {tag, " R4 one frame_done per frame"}, done_cnt, base + 1);
        chk(q.size() == 0, {tag, " R4 all 16 edges seen"}, q.size(), 0);
        chk(sck_out == pol, {tag, " R1 idle level after frame"}, int'(sck_out), int'(pol));
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sck_oe == 1'b0, "R5 oe low after reset while disabled", int'(sck_oe), 0);
        chk(sample_stb == 1'b0 && shift_stb == 1'b0, "R3 no strobes after reset",
            int'(sample_stb | shift_stb), 0);
        chk(sck_out == 1'b1, "R1 idle level follows cpol=1", int'(sck_out), 1);

        // R9: start while disabled is ignored
        pulse_start();
        repeat (50) @(negedge clk);
        chk(done_cnt == 0, "R9 start ignored while disabled", done_cnt, 0);

        @(negedge clk) en = 1'b1;
        @(negedge clk);
        chk(sck_oe == 1'b1, "R5 oe high in enabled master", int'(sck_oe), 1);

        // R9: second start inside a frame is ignored
        @(negedge clk) begin div_code = 4'd3; cpol = 1'b0; cpha = 1'b0; end
        repeat (2) @(negedge clk);
        base = done_cnt;
        push_frame(1'b0, 1'b0, 8, 0, 1);
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done(base + 1);
        repeat (300) @(negedge clk);
        chk(done_cnt == base + 1, "R9 start during frame ignored", done_cnt, base + 1);

        master_frame(4'd0, 1'b0, 1'b0, 1, "code0");
        master_frame(4'd3, 1'b1, 1'b1, 8, "code3");
        master_frame(4'd2, 1'b1, 1'b0, 4, "code2");
        master_frame(4'd12, 1'b0, 1'b1, 512, "R2 code12 saturated");

        // R6 / R7: receive-only free running, disable mid frame
        @(negedge clk) begin en = 1'b0; div_code = 4'd1; cpol = 1'b0; cpha = 1'b0; rx_only = 1'b1; end
        repeat (3) @(negedge clk);
        base = done_cnt;
        push_frame(1'b0, 1'b0, 2, 0, 1);
        push_frame(1'b0, 1'b0, 2, 1, 1);
        push_frame(1'b0, 1'b0, 2, 1, 1);
        @(negedge clk) en = 1'b1;
        wait_done(base + 2);
        chk(done_cnt == base + 2, "R6 two frames without frame_start", done_cnt, base + 2);
        repeat (10) @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk(sck_oe == 1'b1, "R7 oe held while frame finishes", int'(sck_oe), 1);
        wait_done(base + 3);
        repeat (100) @(negedge clk);
        chk(done_cnt == base + 3, "R7 stops after current frame", done_cnt, base + 3);
        chk(q.size() == 0, "R7 all edges of last frame seen", q.size(), 0);
        chk(sck_oe == 1'b0, "R5 oe low after disable", int'(sck_oe), 0);
        chk(sck_out == 1'b0, "R1 idle after receive-only", int'(sck_out), 0);
        rx_only = 1'b0;

        // R8: slave mode, cpol=0 cpha=1
        @(negedge clk) begin master = 1'b0; cpol = 1'b0; cpha = 1'b1; sck_in = 1'b0; end
        repeat (6) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck_oe == 1'b0, "R5 oe low in slave", int'(sck_oe), 0);
        base = done_cnt;
        push_frame(1'b0, 1'b1, 8, 0, 0);
        for (int i = 0; i < 16; i++) begin
            repeat (8) @(negedge clk);
            sck_in = ~sck_in;
        end
        repeat (20) @(negedge clk);
        chk(done_cnt == base + 1, "R8 slave frame_done after 16 edges", done_cnt, base + 1);
        chk(q.size() == 0, "R8 one strobe per slave edge", q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule